// File: doc/BRIEF.md
# Display List Pointer Register Bank

This block keeps the addressing state of a display list coprocessor: two 32-bit program start locations (A and B) and the running program pointer that the coprocessor fetches from. The CPU sets each start location through a 16-bit register port, one half per access. Two strobe offsets reload the running pointer from A or from B. A frame-start pulse from the raster timing also reloads it from A, so every frame's display list runs again from its top.

Fetching and executing coprocessor instructions is not part of this block. The coprocessor only reads the running pointer and pulses a step input after each word it consumes. Every update takes effect on the clock edge after the event. A strobe loads the start location as it stood before that edge.

Top module: `dlist_ptr_bank`

## Requirements
- R1: A write to offset 0x080 sets bits 31:16 of location A, and a write to 0x082 sets bits 15:0 of location A. In both cases the other half keeps its value.
- R2: A write to offset 0x084 sets bits 31:16 of location B, and a write to 0x086 sets bits 15:0 of location B. In both cases the other half keeps its value.
- R3: Any access to offset 0x088, whether a read (acc_wr=0) or a write (acc_wr=1), loads location A into the running pointer. The new value appears on the next clock edge.
- R4: Any access to offset 0x08A, whether a read or a write, loads location B into the running pointer on the next clock edge.
- R5: A frame_wrap pulse loads location A into the running pointer on the next clock edge.
- R6: A step pulse adds 2 to the running pointer, modulo 2^32. Bit 0 of the running pointer is always 0, also after it is loaded from an odd start location.
- R7: When events coincide in one cycle, a CPU strobe wins over frame_wrap, and frame_wrap wins over step.
- R8: An active-low reset clears both start locations and the running pointer to zero.
- R9: Reads of offsets 0x080 to 0x086 have no effect, and neither does any access to another offset. Both start locations and the running pointer keep their values.
- R10: In a cycle with no strobe, no frame_wrap and no step, the running pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | A CPU register access is valid this cycle |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 9 | Register byte offset |
| acc_wdata | input | 16 | Write data |
| frame_wrap | input | 1 | Pulse when the raster wraps from the last line to line 0 |
| step | input | 1 | Pulse from the coprocessor after it consumes one word |
| cur_ptr | output | 32 | Running program pointer |

## Verification
The checker watches every cycle. It tests half writes, including that the other half is preserved, and it tests that each strobe, frame reload and step produces the right next pointer under the priority order. It also tests that the pointer holds when idle, that bit 0 stays clear and that the decoded events are mutually exclusive. The start locations have no read path, so only the bench's scenarios can show them from outside: the bench writes the halves and then reloads them through a strobe. The same holds for reads of the location offsets and accesses to unmapped offsets, which must leave everything unchanged. Wrap-around of the step and the reset values are also checked by bench scenarios.

// File: rtl/dlist_ptr_pkg.sv
package dlist_ptr_pkg;

  // Action chosen for the running pointer in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_STEP    = 2'd1,
    ACT_FRAME   = 2'd2,
    ACT_RESTART = 2'd3
  } cur_act_e;

  // Priority: CPU strobe, then frame reload, then step
  function automatic cur_act_e pick_act(input logic restart, input logic frame,
                                        input logic stp);
    if (restart)    return ACT_RESTART;
    else if (frame) return ACT_FRAME;
    else if (stp)   return ACT_STEP;
    else            return ACT_HOLD;
  endfunction

endpackage

// File: rtl/dlist_ptr_decode.sv
module dlist_ptr_decode #(
  parameter int ADDR_W  = 9,
  parameter int NUM_LOC = 2,
  parameter int BASE    = 'h080,
  localparam int IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic [NUM_LOC-1:0] wr_hi,
  output logic [NUM_LOC-1:0] wr_lo,
  output logic [NUM_LOC-1:0] rst_hit,
  output logic               rst_any,
  output logic [IDX_W-1:0]   rst_idx
);

  // Strobe offsets follow the location register block
  localparam int STROBE_BASE = BASE + 4 * NUM_LOC;

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_dec
    localparam int HI_OFS = BASE + 4 * i;
    localparam int LO_OFS = HI_OFS + 2;
    localparam int RS_OFS = STROBE_BASE + 2 * i;
    localparam logic [ADDR_W-1:0] HI_A = HI_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] LO_A = LO_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] RS_A = RS_OFS[ADDR_W-1:0];

    assign wr_hi[i]   = acc_en && acc_wr && (acc_addr == HI_A);
    assign wr_lo[i]   = acc_en && acc_wr && (acc_addr == LO_A);
    // restart fires on a read or a write
    assign rst_hit[i] = acc_en && (acc_addr == RS_A);
  end

  assign rst_any = |rst_hit;

  always_comb begin
    rst_idx = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (rst_hit[i]) rst_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dlist_ptr_loc.sv
module dlist_ptr_loc #(
  parameter int DATA_W = 16,
  localparam int LOC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [LOC_W-1:0]  loc
);

  // Replace one half of a location, keep the other
  function automatic logic [LOC_W-1:0] merge_half(input logic [LOC_W-1:0] old,
                                                  input logic [DATA_W-1:0] d,
                                                  input logic upper);
    logic [LOC_W-1:0] r;
    r = old;
    if (upper) r[LOC_W-1:DATA_W] = d;
    else       r[DATA_W-1:0]     = d;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     loc <= '0;
    else if (wr_hi) loc <= merge_half(loc, wdata, 1'b1);
    else if (wr_lo) loc <= merge_half(loc, wdata, 1'b0);
  end

endmodule

// File: rtl/dlist_ptr_cursor.sv
module dlist_ptr_cursor
  import dlist_ptr_pkg::*;
#(
  parameter int PTR_W   = 32,
  parameter int NUM_LOC = 2,
  parameter int STEP    = 2,
  localparam int IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LOC-1:0][PTR_W-1:0]   locs,
  input  logic                            rst_any,
  input  logic [IDX_W-1:0]                rst_idx,
  input  logic                            frame_wrap,
  input  logic                            step,
  output cur_act_e                        act,
  output logic [PTR_W-1:0]                cur
);

  // Word alignment: bit 0 never set
  function automatic logic [PTR_W-1:0] word_align(input logic [PTR_W-1:0] x);
    return {x[PTR_W-1:1], 1'b0};
  endfunction

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] x);
    return word_align(x + PTR_W'(STEP));
  endfunction

  logic [PTR_W-1:0] nxt;

  assign act = pick_act(rst_any, frame_wrap, step);

  always_comb begin
    unique case (act)
      ACT_RESTART: nxt = word_align(locs[rst_idx]);
      ACT_FRAME:   nxt = word_align(locs[0]);
      ACT_STEP:    nxt = advance(cur);
      default:     nxt = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

endmodule

// File: rtl/dlist_ptr_bank.sv
module dlist_ptr_bank
  import dlist_ptr_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16,
  parameter int NUM_LOC = 2,
  parameter int BASE    = 'h080,
  parameter int STEP    = 2,
  localparam int PTR_W  = 2 * DATA_W,
  localparam int IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              frame_wrap,
  input  logic              step,
  output logic [PTR_W-1:0]  cur_ptr
);

  // Named internal events, observed by the checker
  logic [NUM_LOC-1:0]            wr_hi;
  logic [NUM_LOC-1:0]            wr_lo;
  logic [NUM_LOC-1:0]            rst_hit;
  logic                          rst_any;
  logic [IDX_W-1:0]              rst_idx;
  logic [NUM_LOC-1:0][PTR_W-1:0] loc_vec;
  cur_act_e                      act;

  dlist_ptr_decode #(
    .ADDR_W (ADDR_W),
    .NUM_LOC(NUM_LOC),
    .BASE   (BASE)
  ) u_decode (
    .acc_en  (acc_en),
    .acc_wr  (acc_wr),
    .acc_addr(acc_addr),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .rst_hit (rst_hit),
    .rst_any (rst_any),
    .rst_idx (rst_idx)
  );

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    dlist_ptr_loc #(
      .DATA_W(DATA_W)
    ) u_loc (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_hi(wr_hi[i]),
      .wr_lo(wr_lo[i]),
      .wdata(acc_wdata),
      .loc  (loc_vec[i])
    );
  end

  dlist_ptr_cursor #(
    .PTR_W  (PTR_W),
    .NUM_LOC(NUM_LOC),
    .STEP   (STEP)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .locs      (loc_vec),
    .rst_any   (rst_any),
    .rst_idx   (rst_idx),
    .frame_wrap(frame_wrap),
    .step      (step),
    .act       (act),
    .cur       (cur_ptr)
  );

endmodule

// File: rtl/dlist_ptr_chk.sv
module dlist_ptr_chk #(
  parameter int DATA_W  = 16,
  parameter int NUM_LOC = 2,
  parameter int STEP    = 2,
  localparam int PTR_W  = 2 * DATA_W,
  localparam int IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [DATA_W-1:0]             acc_wdata,
  input logic                          frame_wrap,
  input logic                          step,
  input logic [PTR_W-1:0]              cur_ptr,
  input logic [NUM_LOC-1:0]            wr_hi,
  input logic [NUM_LOC-1:0]            wr_lo,
  input logic [NUM_LOC-1:0]            rst_hit,
  input logic                          rst_any,
  input logic [IDX_W-1:0]              rst_idx,
  input logic [NUM_LOC-1:0][PTR_W-1:0] loc_vec
);

  logic [PTR_W-1:0] tgt;
  logic [PTR_W-1:0] tgt_al;
  logic [PTR_W-1:0] loc0_al;
  assign tgt     = loc_vec[rst_idx];
  assign tgt_al  = tgt & ~PTR_W'(1);
  assign loc0_al = loc_vec[0] & ~PTR_W'(1);

  // R9
  dec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_hi, wr_lo, rst_hit}));

  // R6
  ptr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ptr[0] == 1'b0);

  // R3
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |=> cur_ptr == $past(tgt_al));

  // R5
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && !rst_any) |=> cur_ptr == $past(loc0_al));

  // R7
  step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !frame_wrap && !rst_any) |=> cur_ptr == $past(cur_ptr) + PTR_W'(STEP));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !frame_wrap && !rst_any) |=> $stable(cur_ptr));

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc_chk
    // R1
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi[i] |=> (loc_vec[i][PTR_W-1:DATA_W] == $past(acc_wdata)) &&
                   (loc_vec[i][DATA_W-1:0] == $past(loc_vec[i][DATA_W-1:0])));
    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo[i] |=> (loc_vec[i][DATA_W-1:0] == $past(acc_wdata)) &&
                   (loc_vec[i][PTR_W-1:DATA_W] == $past(loc_vec[i][PTR_W-1:DATA_W])));
    // R9
    loc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hi[i] && !wr_lo[i]) |=> $stable(loc_vec[i]));
  end

endmodule

bind dlist_ptr_bank dlist_ptr_chk #(
  .DATA_W (DATA_W),
  .NUM_LOC(NUM_LOC),
  .STEP   (STEP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_wdata (acc_wdata),
  .frame_wrap(frame_wrap),
  .step      (step),
  .cur_ptr   (cur_ptr),
  .wr_hi     (wr_hi),
  .wr_lo     (wr_lo),
  .rst_hit   (rst_hit),
  .rst_any   (rst_any),
  .rst_idx   (rst_idx),
  .loc_vec   (loc_vec)
);

// File: tb/test_dlist_ptr_bank.sv
module test_dlist_ptr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [8:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        frame_wrap = 1'b0;
  logic        step = 1'b0;
  logic [31:0] cur_ptr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  // Bench model of the start locations and the pointer
  logic [31:0] m_a = '0;
  logic [31:0] m_b = '0;

  always #2.5 clk = ~clk;

  dlist_ptr_bank i_dlist_ptr_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .frame_wrap(frame_wrap),
    .step      (step),
    .cur_ptr   (cur_ptr)
  );

  function automatic logic [31:0] even(input logic [31:0] x);
    return x & 32'hFFFF_FFFE;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; result is visible once this returns
  task automatic cyc(input logic en, input logic wr, input logic [8:0] a,
                     input logic [15:0] d, input logic fw, input logic st);
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = a; acc_wdata = d;
    frame_wrap = fw; step = st;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; frame_wrap = 1'b0; step = 1'b0;
  endtask

  task automatic wreg(input logic [8:0] a, input logic [15:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R8 pointer after reset", cur_ptr, 32'h0);
    cyc(1'b1, 1'b0, 9'h088, 16'h0, 1'b0, 1'b0);
    chk("R8 location A after reset", cur_ptr, 32'h0);
    cyc(1'b1, 1'b0, 9'h08A, 16'h0, 1'b0, 1'b0);
    chk("R8 location B after reset", cur_ptr, 32'h0);
  endtask

  task automatic t_loc_a;
    wreg(9'h080, 16'h1234); m_a[31:16] = 16'h1234;
    cyc(1'b1, 1'b1, 9'h088, 16'hFFFF, 1'b0, 1'b0);
    chk("R1 R3 hi half via write strobe", cur_ptr, 32'h1234_0000);
    wreg(9'h082, 16'hABCD); m_a[15:0] = 16'hABCD;
    chk("R10 pointer held across location write", cur_ptr, 32'h1234_0000);
    cyc(1'b1, 1'b0, 9'h088, 16'h0, 1'b0, 1'b0);
    chk("R3 R6 read strobe, odd low half", cur_ptr, 32'h1234_ABCC);
    wreg(9'h080, 16'h5678); m_a[31:16] = 16'h5678;
    cyc(1'b1, 1'b0, 9'h088, 16'h0, 1'b0, 1'b0);
    chk("R1 low half kept on hi write", cur_ptr, even(m_a));
  endtask

  task automatic t_loc_b;
    wreg(9'h086, 16'h0100); m_b[15:0] = 16'h0100;
    wreg(9'h084, 16'hCAFE); m_b[31:16] = 16'hCAFE;
    cyc(1'b1, 1'b0, 9'h08A, 16'h0, 1'b0, 1'b0);
    chk("R2 R4 location B via read strobe", cur_ptr, 32'hCAFE_0100);
    wreg(9'h086, 16'h0222); m_b[15:0] = 16'h0222;
    cyc(1'b1, 1'b1, 9'h08A, 16'h0, 1'b0, 1'b0);
    chk("R2 hi half kept on low write", cur_ptr, 32'hCAFE_0222);
    cyc(1'b1, 1'b1, 9'h088, 16'h0, 1'b0, 1'b0);
    chk("R3 location A unaffected by B writes", cur_ptr, even(m_a));
  endtask

  task automatic t_step;
    logic [31:0] e;
    e = cur_ptr;
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, 9'h0, 16'h0, 1'b0, 1'b1);
      e = e + 32'd2;
      chk("R6 step adds two", cur_ptr, e);
    end
    wreg(9'h080, 16'hFFFF); m_a[31:16] = 16'hFFFF;
    wreg(9'h082, 16'hFFFE); m_a[15:0] = 16'hFFFE;
    cyc(1'b1, 1'b0, 9'h088, 16'h0, 1'b0, 1'b0);
    chk("R3 top of address space", cur_ptr, 32'hFFFF_FFFE);
    cyc(1'b0, 1'b0, 9'h0, 16'h0, 1'b0, 1'b1);
    chk("R6 step wraps to zero", cur_ptr, 32'h0);
  endtask

  task automatic t_frame;
    wreg(9'h080, 16'h0004); m_a[31:16] = 16'h0004;
    wreg(9'h082, 16'h2001); m_a[15:0] = 16'h2001;
    cyc(1'b1, 1'b0, 9'h08A, 16'h0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 9'h0, 16'h0, 1'b0, 1'b1);
    chk("R6 step from location B", cur_ptr, even(m_b) + 32'd2);
    cyc(1'b0, 1'b0, 9'h0, 16'h0, 1'b1, 1'b0);
    chk("R5 frame wrap reloads A", cur_ptr, 32'h0004_2000);
  endtask

  task automatic t_prio;
    cyc(1'b1, 1'b0, 9'h08A, 16'h0, 1'b1, 1'b1);
    chk("R7 strobe B beats frame wrap", cur_ptr, even(m_b));
    cyc(1'b0, 1'b0, 9'h0, 16'h0, 1'b1, 1'b1);
    chk("R7 frame wrap beats step", cur_ptr, even(m_a));
    cyc(1'b1, 1'b0, 9'h08A, 16'h0, 1'b0, 1'b1);
    chk("R7 strobe beats step", cur_ptr, even(m_b));
  endtask

  task automatic t_ignore;
    logic [31:0] hold;
    hold = cur_ptr;
    cyc(1'b1, 1'b0, 9'h080, 16'h9999, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 9'h086, 16'h9999, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 9'h090, 16'h9999, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 9'h07E, 16'h9999, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 9'h089, 16'h9999, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 9'h088, 16'h9999, 1'b0, 1'b0);
    chk("R9 R10 pointer unchanged by unmapped access", cur_ptr, hold);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk("R10 pointer held while idle", cur_ptr, hold);
    cyc(1'b1, 1'b0, 9'h088, 16'h0, 1'b0, 1'b0);
    chk("R9 location A unchanged by reads", cur_ptr, even(m_a));
    cyc(1'b1, 1'b0, 9'h08A, 16'h0, 1'b0, 1'b0);
    chk("R9 location B unchanged by reads", cur_ptr, even(m_b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 pointer during reset", cur_ptr, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_loc_a();
    t_loc_b();
    t_step();
    t_frame();
    t_prio();
    t_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule